// File: doc/BRIEF.md
# Shadow Writeback Reduction Merger

This block folds partial results from several processors into one physical memory block. Each processor first reads a shadow alias of the result block. The block answers that read with a block of identity words and marks the processor as a holder of a shadow copy. When the processor later evicts its shadow copy, the writeback arrives as a full 16-word block. The merger adds each word, with wraparound, into the matching word of the physical block, which it holds in a local buffer.

The physical block is fetched from memory before the first merge. It then stays in the buffer across all later merges. It is written back to memory only when the last shadow holder has been merged. A plain read of the block that arrives while shadow holders remain is parked. The block shows the holders that must still give up their copies, and it answers the read with the final data once the last of them has been merged and the block has been flushed. A plain read with no holders left fetches the block from memory and returns it.

Top module: `shadow_merge_unit`

## Requirements
- R1: A shadow read (req_op = 0) is answered with exactly 16 response beats, rsp_idx stepping 0,1,...,15 on consecutive cycles, each carrying the identity value zero.
- R2: An accepted shadow read marks its processor as a shadow holder from the next cycle. A writeback (req_op = 2) from a processor that holds no shadow copy is accepted and discarded: no memory read, no memory write, and the block contents stay unchanged.
- R3: A writeback from a holder adds each of its 16 words (word w at bits 64w+63:64w of req_data) into word w of the physical block, as a 64-bit sum with wraparound.
- R4: While any processor still holds a shadow copy, no memory write is issued. Merges before the last one leave memory untouched.
- R5: When the last holder is merged, the block is written to memory as 16 word writes with mem_idx ascending from 0. flush_done pulses for one cycle, in the cycle after the last write.
- R6: req_ready is low from the cycle after a holder's writeback is accepted until its load, merge and any flush or response have ended.
- R7: A plain read (req_op = 1) that arrives while holders remain is accepted and held. recall_vec shows the remaining holders, bit p for processor p. Shadow reads and plain reads stall meanwhile. The read is answered with the fully merged block after the flush.
- R8: A plain read with no holders returns the 16 memory words unchanged, in index order.
- R9: After reset req_ready is high, and rsp_valid, mem_rd_en, mem_wr_en, flush_done and recall_vec are all zero.
- R10: Before the first merge, or before a plain read with no holders, the block is fetched from memory as 16 word reads with mem_idx ascending from 0. Read data is returned one cycle after mem_rd_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_op | input | 2 | 0 shadow read, 1 plain read, 2 shadow writeback |
| req_proc | input | 2 | Requesting processor |
| req_data | input | 1024 | Writeback block, word w in bits 64w+63:64w |
| rsp_valid | output | 1 | Response beat valid |
| rsp_idx | output | 4 | Word index of the response beat |
| rsp_data | output | 64 | Response word |
| mem_rd_en | output | 1 | Memory word read |
| mem_wr_en | output | 1 | Memory word write |
| mem_idx | output | 4 | Memory word index |
| mem_wr_data | output | 64 | Memory write word |
| mem_rd_data | input | 64 | Memory read word, one cycle after mem_rd_en |
| recall_vec | output | 4 | Holders blocking a parked plain read |
| flush_done | output | 1 | One-cycle pulse after the block is written back |

## Verification
The assertions check several properties on every cycle. Response indices advance by one within a response. Memory is never written while a holder remains. An accepted shadow read leaves its holder bit set, and an accepted holder writeback drops req_ready. flush_done always follows the write of the last word. Only the bench's scenarios can show the arithmetic: that wrapped sums of four writebacks reach memory in full, that a parked plain read returns the merged data, and that a writeback from a non-holder leaves the block unchanged when it is read back.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic [1:0] {
    OP_SHADOW_RD = 2'd0,
    OP_PLAIN_RD  = 2'd1,
    OP_WRITEBACK = 2'd2
  } smr_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_MERGE,
    ST_FLUSH,
    ST_RSP_ID,
    ST_RSP_DATA
  } smr_state_e;
endpackage

// File: rtl/smr_buf_ram.sv
module smr_buf_ram #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/smr_owner_track.sv
module smr_owner_track #(
  parameter int PROCS = 4,
  localparam int PW = (PROCS > 1) ? $clog2(PROCS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [PW-1:0]    set_idx,
  input  logic             clr_en,
  input  logic [PW-1:0]    clr_idx,
  output logic [PROCS-1:0] owners,
  output logic             empty_after_clr
);
  for (genvar i = 0; i < PROCS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                                  owners[i] <= 1'b0;
      else if (set_en && set_idx == PW'(i))     owners[i] <= 1'b1;
      else if (clr_en && clr_idx == PW'(i))     owners[i] <= 1'b0;
    end
  end

  always_comb begin
    logic [PROCS-1:0] keep;
    for (int i = 0; i < PROCS; i++) keep[i] = owners[i] && (clr_idx != PW'(i));
    empty_after_clr = (keep == '0);
  end
endmodule

// File: rtl/smr_word_adder.sv
module smr_word_adder #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  assign y = a + b;
endmodule

// File: rtl/shadow_merge_unit.sv
module shadow_merge_unit
  import smr_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int WORDS  = 16,
  parameter int PROCS  = 4,
  parameter logic [WORD_W-1:0] IDENTITY = '0,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int PROC_W = (PROCS > 1) ? $clog2(PROCS) : 1,
  localparam int BLK_W  = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [PROC_W-1:0] req_proc,
  input  logic [BLK_W-1:0]  req_data,
  output logic              rsp_valid,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [WORD_W-1:0] rsp_data,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [WORD_W-1:0] mem_wr_data,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic [PROCS-1:0]  recall_vec,
  output logic              flush_done
);
  localparam int CNT_W = $clog2(WORDS + 2);
  localparam logic [CNT_W-1:0] C_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_TWO   = CNT_W'(2);
  localparam logic [CNT_W-1:0] C_WORDS = CNT_W'(WORDS);
  localparam logic [CNT_W-1:0] C_LDEND = CNT_W'(WORDS + 1);
  localparam logic [CNT_W-1:0] C_IDEND = CNT_W'(WORDS - 1);

  smr_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              resident;
  logic              pend_rd;
  logic              load_for_merge;
  logic              done_arm;
  logic [WORD_W-1:0] wb_q [WORDS];
  logic [PROC_W-1:0] wb_proc_q;

  logic [PROCS-1:0]  owner_vec;
  logic              owners_drain;
  logic              owner_hit;
  logic              accept;
  logic              set_owner;
  logic              clr_owner;

  logic [IDX_W-1:0]  idx_cur;
  logic [IDX_W-1:0]  idx_m1;
  logic [IDX_W-1:0]  idx_m2;
  logic              ram_we;
  logic [IDX_W-1:0]  ram_waddr;
  logic [WORD_W-1:0] ram_wdata;
  logic [IDX_W-1:0]  ram_raddr;
  logic [WORD_W-1:0] ram_q;
  logic [WORD_W-1:0] merge_sum;

  assign idx_cur = IDX_W'(cnt);
  assign idx_m1  = IDX_W'(cnt - C_ONE);
  assign idx_m2  = IDX_W'(cnt - C_TWO);

  assign owner_hit = owner_vec[req_proc];
  assign req_ready = (state == ST_IDLE) && !(pend_rd && req_op != OP_WRITEBACK);
  assign accept    = req_valid && req_ready;
  assign set_owner = accept && (req_op == OP_SHADOW_RD);
  assign clr_owner = (state == ST_MERGE) && (cnt == C_WORDS);

  smr_owner_track #(.PROCS(PROCS)) u_owners (
    .clk             (clk),
    .rst             (rst),
    .set_en          (set_owner),
    .set_idx         (req_proc),
    .clr_en          (clr_owner),
    .clr_idx         (wb_proc_q),
    .owners          (owner_vec),
    .empty_after_clr (owners_drain)
  );

  smr_word_adder #(.WIDTH(WORD_W)) u_add (
    .a (ram_q),
    .b (wb_q[idx_m1]),
    .y (merge_sum)
  );

  smr_buf_ram #(.WIDTH(WORD_W), .DEPTH(WORDS)) u_buf (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = idx_m1;
    ram_wdata = merge_sum;
    ram_raddr = (cnt < C_WORDS) ? idx_cur : '0;
    case (state)
      ST_LOAD: begin
        ram_we    = (cnt >= C_TWO);
        ram_waddr = idx_m2;
        ram_wdata = mem_rd_data;
      end
      ST_MERGE: begin
        ram_we    = (cnt >= C_ONE);
        ram_waddr = idx_m1;
        ram_wdata = merge_sum;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      cnt            <= '0;
      resident       <= 1'b0;
      pend_rd        <= 1'b0;
      load_for_merge <= 1'b0;
      done_arm       <= 1'b0;
      wb_proc_q      <= '0;
      rsp_valid      <= 1'b0;
      rsp_idx        <= '0;
      rsp_data       <= '0;
      mem_rd_en      <= 1'b0;
      mem_wr_en      <= 1'b0;
      mem_idx        <= '0;
      mem_wr_data    <= '0;
      recall_vec     <= '0;
      flush_done     <= 1'b0;
    end else begin
      rsp_valid  <= 1'b0;
      mem_rd_en  <= 1'b0;
      mem_wr_en  <= 1'b0;
      done_arm   <= 1'b0;
      flush_done <= done_arm;
      recall_vec <= pend_rd ? owner_vec : '0;

      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (accept) begin
            case (req_op)
              OP_SHADOW_RD: state <= ST_RSP_ID;
              OP_PLAIN_RD: begin
                if (owner_vec != '0) begin
                  pend_rd <= 1'b1;
                end else begin
                  load_for_merge <= 1'b0;
                  state          <= ST_LOAD;
                end
              end
              OP_WRITEBACK: begin
                if (owner_hit) begin
                  wb_proc_q      <= req_proc;
                  load_for_merge <= 1'b1;
                  state          <= resident ? ST_MERGE : ST_LOAD;
                end
              end
              default: ;
            endcase
          end
        end

        ST_LOAD: begin
          cnt <= cnt + C_ONE;
          if (cnt < C_WORDS) begin
            mem_rd_en <= 1'b1;
            mem_idx   <= idx_cur;
          end
          if (cnt == C_LDEND) begin
            cnt      <= '0;
            resident <= 1'b1;
            state    <= load_for_merge ? ST_MERGE : ST_RSP_DATA;
          end
        end

        ST_MERGE: begin
          cnt <= cnt + C_ONE;
          if (cnt == C_WORDS) begin
            cnt   <= '0;
            state <= owners_drain ? ST_FLUSH : ST_IDLE;
          end
        end

        ST_FLUSH: begin
          cnt <= cnt + C_ONE;
          if (cnt >= C_ONE) begin
            mem_wr_en   <= 1'b1;
            mem_idx     <= idx_m1;
            mem_wr_data <= ram_q;
          end
          if (cnt == C_WORDS) begin
            cnt      <= '0;
            done_arm <= 1'b1;
            if (pend_rd) begin
              state <= ST_RSP_DATA;
            end else begin
              state    <= ST_IDLE;
              resident <= 1'b0;
            end
          end
        end

        ST_RSP_ID: begin
          cnt       <= cnt + C_ONE;
          rsp_valid <= 1'b1;
          rsp_idx   <= idx_cur;
          rsp_data  <= IDENTITY;
          if (cnt == C_IDEND) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end
        end

        ST_RSP_DATA: begin
          cnt <= cnt + C_ONE;
          if (cnt >= C_ONE) begin
            rsp_valid <= 1'b1;
            rsp_idx   <= idx_m1;
            rsp_data  <= ram_q;
          end
          if (cnt == C_WORDS) begin
            cnt      <= '0;
            state    <= ST_IDLE;
            resident <= 1'b0;
            pend_rd  <= 1'b0;
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept && req_op == OP_WRITEBACK && owner_hit) begin
      for (int w = 0; w < WORDS; w++) wb_q[w] <= req_data[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
  parameter int WORDS = 16,
  parameter int PROCS = 4,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int PROC_W = (PROCS > 1) ? $clog2(PROCS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [PROC_W-1:0] req_proc,
  input logic              rsp_valid,
  input logic [IDX_W-1:0]  rsp_idx,
  input logic              mem_wr_en,
  input logic [IDX_W-1:0]  mem_idx,
  input logic              flush_done,
  input logic [PROCS-1:0]  owner_vec
);
  AST_RSP_STEP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && $past(rsp_valid) |-> rsp_idx == IDX_W'($past(rsp_idx) + 1'b1)); // R1

  AST_SHADOW_OWNER: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && req_ready && req_op == 2'd0) |-> owner_vec[$past(req_proc)]); // R2

  AST_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> owner_vec == '0); // R4

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    flush_done |-> $past(mem_wr_en) && $past(mem_idx) == IDX_W'(WORDS - 1)); // R5

  AST_WB_STALL: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && req_ready && req_op == 2'd2 && owner_vec[req_proc]) |-> !req_ready); // R6
endmodule

bind shadow_merge_unit smr_checker #(.WORDS(WORDS), .PROCS(PROCS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .req_proc   (req_proc),
  .rsp_valid  (rsp_valid),
  .rsp_idx    (rsp_idx),
  .mem_wr_en  (mem_wr_en),
  .mem_idx    (mem_idx),
  .flush_done (flush_done),
  .owner_vec  (owner_vec)
);

// File: tb/shadow_merge_unit_test.sv
module shadow_merge_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 64;
  localparam int NW = 16;
  localparam int NP = 4;
  localparam int IW = 4;
  localparam int PW = 2;

  logic clk, rst;
  logic req_valid, req_ready;
  logic [1:0] req_op;
  logic [PW-1:0] req_proc;
  logic [NW*WW-1:0] req_data;
  logic rsp_valid;
  logic [IW-1:0] rsp_idx;
  logic [WW-1:0] rsp_data;
  logic mem_rd_en, mem_wr_en;
  logic [IW-1:0] mem_idx;
  logic [WW-1:0] mem_wr_data, mem_rd_data;
  logic [NP-1:0] recall_vec;
  logic flush_done;

  logic [WW-1:0] bmem [NW];
  logic [WW-1:0] exp_v [NW];
  logic [WW-1:0] rsp_cap [NW];
  int checks = 0, errors = 0;
  int rsp_cnt = 0, rsp_order_err = 0;
  int wr_cnt = 0, wr_order_err = 0;
  int rd_cnt = 0, rd_order_err = 0;
  int done_cnt = 0;

  shadow_merge_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_proc(req_proc), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_data(rsp_data),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_idx(mem_idx),
    .mem_wr_data(mem_wr_data), .mem_rd_data(mem_rd_data),
    .recall_vec(recall_vec), .flush_done(flush_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= bmem[mem_idx];
    if (mem_wr_en) bmem[mem_idx] <= mem_wr_data;
  end

  always @(negedge clk) begin
    if (rsp_valid) begin
      if (rsp_idx != IW'(rsp_cnt)) rsp_order_err++;
      rsp_cap[rsp_idx] = rsp_data;
      rsp_cnt++;
    end
    if (mem_wr_en) begin
      if (mem_idx != IW'(wr_cnt)) wr_order_err++;
      wr_cnt++;
    end
    if (mem_rd_en) begin
      if (mem_idx != IW'(rd_cnt)) rd_order_err++;
      rd_cnt++;
    end
    if (flush_done) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op, input int p, input logic [NW*WW-1:0] d,
                      output logic rdy_after);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_proc = PW'(p); req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    rdy_after = req_ready;
    req_valid = 1'b0;
  endtask

  function automatic logic [WW-1:0] pat(input int p, input int w);
    return 64'hFFFF_FFFF_FFFF_FF00 + 64'(p * 257) + 64'(w * 13);
  endfunction

  function automatic logic [NW*WW-1:0] blk(input int p);
    logic [NW*WW-1:0] r;
    for (int w = 0; w < NW; w++) r[w*WW +: WW] = pat(p, w);
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic r;
    int r0, w0, rd0, d0;
    rst = 1'b1; req_valid = 1'b0; req_op = 2'd0; req_proc = '0; req_data = '0;
    for (int w = 0; w < NW; w++) begin
      bmem[w]  = 64'h1000 * 64'(w) + 64'h5;
      exp_v[w] = bmem[w];
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    chk(req_ready == 1'b1, "R9", "req_ready", 64'(req_ready), 64'd1);
    chk(!rsp_valid && !mem_rd_en && !mem_wr_en && !flush_done, "R9", "valid outputs",
        {rsp_valid, mem_rd_en, mem_wr_en, flush_done}, 64'd0);
    chk(recall_vec == '0, "R9", "recall_vec", 64'(recall_vec), 64'd0);

    // R8 / R10 plain read with no holders
    r0 = rsp_cnt; rd0 = rd_cnt;
    send(2'd1, 0, '0, r);
    settle(60);
    chk(rd_cnt - rd0 == NW && rd_order_err == 0, "R10", "ascending reads",
        64'(rd_cnt - rd0), 64'(NW));
    chk(rsp_cnt - r0 == NW && rsp_order_err == 0, "R8", "beat count", 64'(rsp_cnt - r0), 64'(NW));
    for (int w = 0; w < NW; w++) chk(rsp_cap[w] == exp_v[w], "R8", "plain word", rsp_cap[w], exp_v[w]);

    // R1 shadow reads from every processor
    for (int p = 0; p < NP; p++) begin
      r0 = rsp_cnt;
      send(2'd0, p, '0, r);
      settle(25);
      chk(rsp_cnt - r0 == NW && rsp_order_err == 0, "R1", "identity beats", 64'(rsp_cnt - r0), 64'(NW));
      for (int w = 0; w < NW; w++) chk(rsp_cap[w] == '0, "R1", "identity word", rsp_cap[w], 64'd0);
    end

    // R3 R4 R5 R6 four merges, order 2,0,3,1
    for (int k = 0; k < NP; k++) begin
      int p;
      p = (k == 0) ? 2 : (k == 1) ? 0 : (k == 2) ? 3 : 1;
      w0 = wr_cnt; d0 = done_cnt;
      send(2'd2, p, blk(p), r);
      chk(r == 1'b0, "R6", "stall after writeback", 64'(r), 64'd0);
      for (int w = 0; w < NW; w++) exp_v[w] = exp_v[w] + pat(p, w);
      settle(70);
      if (k < NP - 1) begin
        chk(wr_cnt == w0 && done_cnt == d0, "R4", "no write with holders", 64'(wr_cnt - w0), 64'd0);
      end else begin
        chk(wr_cnt - w0 == NW && wr_order_err == 0, "R5", "flush writes", 64'(wr_cnt - w0), 64'(NW));
        chk(done_cnt - d0 == 1, "R5", "flush_done pulses", 64'(done_cnt - d0), 64'd1);
        for (int w = 0; w < NW; w++) chk(bmem[w] == exp_v[w], "R3", "merged word", bmem[w], exp_v[w]);
      end
    end

    // R7 plain read parked behind holders 0 and 1
    send(2'd0, 0, '0, r); settle(25);
    send(2'd0, 1, '0, r); settle(25);
    r0 = rsp_cnt;
    send(2'd1, 0, '0, r);
    settle(5);
    chk(recall_vec == 4'b0011, "R7", "recall holders", 64'(recall_vec), 64'h3);
    req_op = 2'd0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R7", "shadow read stalls", 64'(req_ready), 64'd0);
    chk(rsp_cnt == r0, "R7", "no early answer", 64'(rsp_cnt - r0), 64'd0);
    send(2'd2, 0, blk(0), r);
    for (int w = 0; w < NW; w++) exp_v[w] = exp_v[w] + pat(0, w);
    settle(60);
    chk(recall_vec == 4'b0010, "R7", "recall after first", 64'(recall_vec), 64'h2);
    send(2'd2, 1, blk(1), r);
    for (int w = 0; w < NW; w++) exp_v[w] = exp_v[w] + pat(1, w);
    settle(70);
    chk(rsp_cnt - r0 == NW, "R7", "parked answer beats", 64'(rsp_cnt - r0), 64'(NW));
    for (int w = 0; w < NW; w++) chk(rsp_cap[w] == exp_v[w], "R7", "parked answer word", rsp_cap[w], exp_v[w]);
    chk(recall_vec == '0, "R7", "recall cleared", 64'(recall_vec), 64'd0);

    // R2 writeback from a non-holder is discarded
    w0 = wr_cnt; rd0 = rd_cnt;
    send(2'd2, 3, blk(3), r);
    chk(r == 1'b1, "R2", "non-holder stays idle", 64'(r), 64'd1);
    settle(50);
    chk(wr_cnt == w0 && rd_cnt == rd0, "R2", "no memory traffic", 64'(wr_cnt - w0 + rd_cnt - rd0), 64'd0);
    r0 = rsp_cnt;
    send(2'd1, 0, '0, r);
    settle(60);
    chk(rsp_cnt - r0 == NW, "R2", "readback beats", 64'(rsp_cnt - r0), 64'(NW));
    for (int w = 0; w < NW; w++) chk(rsp_cap[w] == exp_v[w], "R2", "block unchanged", rsp_cap[w], exp_v[w]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule